// File: doc/BRIEF.md
# Ordered Power Rail Sequencer

This block drives the enable lines of up to four supply rails so that they switch in a chosen order. Each channel gets one of eight time slots from a position code. When the run input goes high, the block works through the slots in ascending order. For each slot it counts a programmed settle delay and then raises the enables of every channel placed in that slot. It then waits until the comparator flag of each of those rails reports that the rail has reached its up-threshold. When the run input goes low, the block does the same in descending slot order: it lowers enables and waits for the below-down-threshold flags.

A shared power-good watchdog starts counting on the first enable change of a sequence. If it expires before the sequence finishes, the block drops every enable and latches an active-low fault. Each channel also has a mode. A channel can take part in sequencing, be held off, or be held on regardless of sequencing. A cascade output is high while a settle delay is counting. The delay and watchdog limits are cycle counts. They are captured only while the block is idle.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, every enable of a sequenced channel is low, cascade is low and the fault output is high.
- R2: On a high run input, sequenced enables rise slot by slot in ascending order of position code (code 0 is the first slot). Channels that share a code rise on the same cycle.
- R3: Each slot costs D+1 cycles of settle delay, where D is the delay setting, and the cascade output is high throughout that delay. The first slot's delay starts on the cycle after the run input is sampled high. An enable changes on the same edge where its slot's delay ends.
- R4: The next slot's delay starts only after every sequenced channel in the current slot reports its threshold flag. A stalled rail holds the sequence for as long as it stays stalled.
- R5: A slot with no sequenced channel costs exactly D+1 cycles and has no threshold wait, so a full sequence keeps cascade high for 8·(D+1) cycles in total.
- R6: On a low run input after a completed up sequence, enables fall in descending slot order. Each fall uses the same delay and waits on the below-down-threshold flags.
- R7: The watchdog starts on the first enable change of a sequence. If the sequence is still unfinished L+1 cycles later (L = limit setting, nonzero), all enables go low and the fault output goes low.
- R8: A watchdog limit of 0 disables the timeout, so a stalled sequence waits with no fault.
- R9: The fault stays latched while the run input stays high and after it falls. It clears only when the run input rises again, which also starts a new up sequence.
- R10: A channel in mode 2'b01 (held off) keeps its enable low. Its flags are never waited on.
- R11: A channel in mode 2'b10 (held on) drives its enable high at all times, including before any sequence, except while the fault is latched. Modes 2'b00 and 2'b11 mean sequenced.
- R12: A change of the run input during a sequence reverses direction from the current slot. Slots not yet reached in the old direction are never switched.
- R13: The delay and limit settings are captured only while idle (off, fully on, or faulted). A change during a sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| on_i | input | 1 | Run request: high sequences up, low sequences down |
| up_ok_i | input | N_CH | Per channel: rail above its up-threshold |
| dn_ok_i | input | N_CH | Per channel: rail below its down-threshold |
| pos_i | input | N_CH*POS_W | Per channel slot code, channel c at bits [c*POS_W +: POS_W] |
| mode_i | input | 2*N_CH | Per channel mode, channel c at bits [2c +: 2] |
| seq_dly_i | input | CNT_W | Settle delay setting D in cycles |
| pg_lim_i | input | CNT_W | Watchdog limit L in cycles, 0 disables |
| en_o | output | N_CH | Rail enables |
| cas_o | output | 1 | High during each settle delay |
| flt_no | output | 1 | Latched sequence fault, active low |

## Verification
Random slot maps with shared and empty slots, random rail latencies and random delays are checked for the exact rise and fall cycle of every enable. These checks separate errors in slot order, in delay length and in the threshold wait. The total cascade time shows whether empty slots are skipped correctly. Directed cases cover several conditions: a rail stuck below threshold with the watchdog on and with it off, a fault followed by a run toggle, and held-on and held-off channels. They also cover a run input dropped partway up and a delay change in the middle of a sequence. Together these tell apart timeout, latching, mode and reversal faults.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_DLY,
    ST_WAIT,
    ST_ON,
    ST_FLT
  } seq_st_e;

  localparam logic [1:0] MD_OFF = 2'b01;
  localparam logic [1:0] MD_ON  = 2'b10;
endpackage

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (run_i && cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == lim_i);
endmodule

// File: rtl/pseq_decode.sv
module pseq_decode
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned POS_W = 3
) (
  input  logic [N_CH*POS_W-1:0] pos_i,
  input  logic [2*N_CH-1:0]     mode_i,
  input  logic [POS_W-1:0]      cur_i,
  input  logic [N_CH-1:0]       up_ok_i,
  input  logic [N_CH-1:0]       dn_ok_i,
  output logic [N_CH-1:0]       hit_o,
  output logic [N_CH-1:0]       frc_off_o,
  output logic [N_CH-1:0]       frc_on_o,
  output logic                  up_all_o,
  output logic                  dn_all_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign frc_off_o[g] = (mode_i[2*g +: 2] == MD_OFF);
    assign frc_on_o[g]  = (mode_i[2*g +: 2] == MD_ON);
    assign hit_o[g]     = !frc_off_o[g] && !frc_on_o[g] &&
                          (pos_i[g*POS_W +: POS_W] == cur_i);
  end

  assign up_all_o = &(~hit_o | up_ok_i);
  assign dn_all_o = &(~hit_o | dn_ok_i);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned POS_W = 3,
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  on_i,
  input  logic [N_CH-1:0]       up_ok_i,
  input  logic [N_CH-1:0]       dn_ok_i,
  input  logic [N_CH*POS_W-1:0] pos_i,
  input  logic [2*N_CH-1:0]     mode_i,
  input  logic [CNT_W-1:0]      seq_dly_i,
  input  logic [CNT_W-1:0]      pg_lim_i,
  output logic [N_CH-1:0]       en_o,
  output logic                  cas_o,
  output logic                  flt_no
);
  localparam logic [POS_W-1:0] POS_LAST = '1;

  seq_st_e          st_q, st_d;
  logic             up_q, up_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [N_CH-1:0]  sen_q, sen_d;
  logic             flt_q, flt_d;
  logic             pg_run_q, pg_run_d;
  logic [CNT_W-1:0] dly_q, lim_q;
  logic             dly_restart, pg_clr, fault_evt, adv;
  logic             dly_hit, pg_hit;
  logic [N_CH-1:0]  hit, frc_off, frc_on;
  logic             up_all, dn_all;

  pseq_decode #(.N_CH(N_CH), .POS_W(POS_W)) u_dec (
    .pos_i    (pos_i),
    .mode_i   (mode_i),
    .cur_i    (pos_q),
    .up_ok_i  (up_ok_i),
    .dn_ok_i  (dn_ok_i),
    .hit_o    (hit),
    .frc_off_o(frc_off),
    .frc_on_o (frc_on),
    .up_all_o (up_all),
    .dn_all_o (dn_all)
  );

  pseq_timer #(.CNT_W(CNT_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i ((st_q != ST_DLY) || dly_restart),
    .run_i (1'b1),
    .lim_i (dly_q),
    .hit_o (dly_hit)
  );

  pseq_timer #(.CNT_W(CNT_W)) u_pg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (pg_clr),
    .run_i (pg_run_q),
    .lim_i (lim_q),
    .hit_o (pg_hit)
  );

  always_comb begin
    st_d        = st_q;
    up_d        = up_q;
    pos_d       = pos_q;
    sen_d       = sen_q;
    flt_d       = flt_q;
    pg_run_d    = pg_run_q;
    dly_restart = 1'b0;
    pg_clr      = 1'b0;
    fault_evt   = 1'b0;
    adv         = 1'b0;
    case (st_q)
      ST_OFF: if (on_i) begin
        up_d = 1'b1; pos_d = '0; st_d = ST_DLY; flt_d = 1'b0;
        pg_clr = 1'b1; pg_run_d = 1'b0;
      end
      ST_ON: if (!on_i) begin
        up_d = 1'b0; pos_d = POS_LAST; st_d = ST_DLY;
        pg_clr = 1'b1; pg_run_d = 1'b0;
      end
      ST_FLT: if (!on_i) st_d = ST_OFF;
      ST_DLY, ST_WAIT: begin
        if (pg_run_q && lim_q != '0 && pg_hit) begin
          fault_evt = 1'b1; st_d = ST_FLT; flt_d = 1'b1; sen_d = '0;
          pg_run_d = 1'b0; pg_clr = 1'b1;
        end else if (on_i != up_q) begin
          // reverse from current slot
          up_d = on_i; pg_clr = 1'b1; pg_run_d = 1'b0; dly_restart = 1'b1;
          if (st_q == ST_WAIT) st_d = ST_DLY;
          else if (up_q) begin
            if (pos_q == '0) st_d = ST_OFF;
            else begin pos_d = pos_q - 1'b1; st_d = ST_DLY; end
          end else begin
            if (pos_q == POS_LAST) st_d = ST_ON;
            else begin pos_d = pos_q + 1'b1; st_d = ST_DLY; end
          end
        end else if (st_q == ST_DLY && dly_hit) begin
          sen_d = up_q ? (sen_q | hit) : (sen_q & ~hit);
          if (|hit) begin st_d = ST_WAIT; pg_run_d = 1'b1; end
          else adv = 1'b1;
        end else if (st_q == ST_WAIT && (up_q ? up_all : dn_all)) begin
          adv = 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
    if (adv) begin
      if (up_q ? (pos_q == POS_LAST) : (pos_q == '0)) begin
        st_d = up_q ? ST_ON : ST_OFF; pg_clr = 1'b1; pg_run_d = 1'b0;
      end else begin
        pos_d = up_q ? pos_q + 1'b1 : pos_q - 1'b1;
        st_d = ST_DLY; dly_restart = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OFF;
      up_q     <= 1'b0;
      pos_q    <= '0;
      sen_q    <= '0;
      flt_q    <= 1'b0;
      pg_run_q <= 1'b0;
      dly_q    <= '0;
      lim_q    <= '0;
    end else begin
      st_q     <= st_d;
      up_q     <= up_d;
      pos_q    <= pos_d;
      sen_q    <= sen_d;
      flt_q    <= flt_d;
      pg_run_q <= pg_run_d;
      if (st_q == ST_OFF || st_q == ST_ON || st_q == ST_FLT) begin
        dly_q <= seq_dly_i;
        lim_q <= pg_lim_i;
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_en
    assign en_o[g] = !flt_q && (frc_on[g] || (!frc_off[g] && sen_q[g]));

    // R10
    frc_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frc_off[g] |-> !sen_q[g]);
  end

  assign cas_o  = (st_q == ST_DLY);
  assign flt_no = !flt_q;

  // R3
  en_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sen_q != $past(sen_q)) |-> (($past(st_q) == ST_DLY && $past(dly_hit)) || $past(fault_evt)));

  // R7
  flt_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flt_q) |-> ($past(st_q) == ST_DLY || $past(st_q) == ST_WAIT));

  // R8
  pg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DLY || st_q == ST_WAIT) && lim_q == '0 && !flt_q) |=> !flt_q);

  // R9
  flt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flt_q) |-> ($past(st_q) == ST_OFF && $past(on_i)));

  // R4
  wait_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && st_d == ST_DLY && on_i == up_q) |-> (up_q ? up_all : dn_all));
endmodule

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;
  localparam int N = 4;
  localparam int PW = 3;
  localparam int CW = 16;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            on_i = 1'b0;
  logic [N-1:0]    up_ok_i = '0;
  logic [N-1:0]    dn_ok_i = '1;
  logic [N*PW-1:0] pos_i = '0;
  logic [2*N-1:0]  mode_i = '0;
  logic [CW-1:0]   seq_dly_i = '0;
  logic [CW-1:0]   pg_lim_i = '0;
  logic [N-1:0]    en_o;
  logic            cas_o;
  logic            flt_no;

  pwr_seq_ctrl #(.N_CH(N), .POS_W(PW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .on_i(on_i), .up_ok_i(up_ok_i), .dn_ok_i(dn_ok_i),
    .pos_i(pos_i), .mode_i(mode_i), .seq_dly_i(seq_dly_i), .pg_lim_i(pg_lim_i),
    .en_o(en_o), .cas_o(cas_o), .flt_no(flt_no)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, cur_d = 0;
  int pos[N], md[N], lat[N], scnt[N], rise[N], fall[N];
  bit stuck[N], pen[N];
  int cas_sum, cas_run, cas_bad;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // rail model and monitor
  initial begin
    for (int c = 0; c < N; c++) begin scnt[c] = 0; pen[c] = 0; stuck[c] = 0; lat[c] = 1; end
    forever begin
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
        if (en_o[c] && !pen[c]) rise[c] = cyc;
        if (!en_o[c] && pen[c]) fall[c] = cyc;
        pen[c] = en_o[c];
        if (en_o[c] && scnt[c] < lat[c]) scnt[c]++;
        else if (!en_o[c] && scnt[c] > 0) scnt[c]--;
        up_ok_i[c] = !stuck[c] && (scnt[c] == lat[c]);
        dn_ok_i[c] = (scnt[c] == 0);
      end
      if (cas_o) begin cas_sum++; cas_run++; end
      else if (cas_run > 0) begin
        if (cas_run % (cur_d + 1) != 0) cas_bad++;
        cas_run = 0;
      end
    end
  end

  task automatic clr_mon();
    for (int c = 0; c < N; c++) begin rise[c] = -1; fall[c] = -1; end
    cas_sum = 0; cas_run = 0; cas_bad = 0;
  endtask

  task automatic apply_cfg();
    for (int c = 0; c < N; c++) begin
      pos_i[c*PW +: PW] = pos[c][PW-1:0];
      mode_i[2*c +: 2] = md[c][1:0];
    end
  endtask

  function automatic int exp_edge(int t0, int pt, bit up);
    int e = t0 + 1;
    for (int k = 0; k < 8; k++) begin
      int p = up ? k : 7 - k;
      int ml = 0;
      bit occ = 0;
      e += cur_d + 1;
      if (p == pt) return e;
      for (int c = 0; c < N; c++)
        if (md[c] == 0 && pos[c] == p) begin occ = 1; if (lat[c] > ml) ml = lat[c]; end
      if (occ) e += ml;
    end
    return -1;
  endfunction

  function automatic int budget();
    return 8 * (cur_d + 1) + 8 * 8 + 30;
  endfunction

  task automatic run_up(bit chg);
    int t0;
    clr_mon();
    @(negedge clk); on_i = 1'b1; t0 = cyc;
    if (chg) begin @(negedge clk); seq_dly_i = CW'(cur_d + 6); end
    repeat (budget()) @(negedge clk);
    seq_dly_i = CW'(cur_d);
    for (int c = 0; c < N; c++)
      if (md[c] == 0) chk(rise[c] == exp_edge(t0, pos[c], 1'b1),
        chg ? "R13" : "R2 R4", "rise cycle", rise[c], exp_edge(t0, pos[c], 1'b1));
    chk(cas_sum == 8 * (cur_d + 1), "R5", "cascade cycles up", cas_sum, 8 * (cur_d + 1));
    chk(cas_bad == 0, "R3", "cascade runs off delay grid", cas_bad, 0);
  endtask

  task automatic run_dn();
    int t0;
    clr_mon();
    @(negedge clk); on_i = 1'b0; t0 = cyc;
    repeat (budget()) @(negedge clk);
    for (int c = 0; c < N; c++)
      if (md[c] == 0) chk(fall[c] == exp_edge(t0, pos[c], 1'b0),
        "R6", "fall cycle", fall[c], exp_edge(t0, pos[c], 1'b0));
    chk(cas_sum == 8 * (cur_d + 1), "R6", "cascade cycles down", cas_sum, 8 * (cur_d + 1));
  endtask

  task automatic set_d(int d, int l);
    cur_d = d; seq_dly_i = CW'(d); pg_lim_i = CW'(l);
  endtask

  initial begin
    int t0;
    void'($urandom(32'd4711));
    for (int c = 0; c < N; c++) begin pos[c] = c; md[c] = 0; end
    apply_cfg();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(en_o == '0, "R1", "enables after reset", en_o, 0);
    chk(cas_o == 1'b0, "R1", "cascade after reset", cas_o, 0);
    chk(flt_no == 1'b1, "R1", "fault after reset", flt_no, 1);

    // random maps, shared and empty slots
    for (int it = 0; it < 6; it++) begin
      for (int c = 0; c < N; c++) begin
        pos[c] = $urandom_range(7); md[c] = 0; lat[c] = $urandom_range(6, 1); stuck[c] = 0;
      end
      set_d($urandom_range(5), 0);
      apply_cfg();
      repeat (20) @(negedge clk);
      run_up(1'b0);
      run_dn();
    end

    // R13: delay changed mid-sequence
    pos = '{2, 2, 5, 0}; md = '{0, 0, 0, 0}; lat = '{2, 4, 1, 3};
    set_d(3, 0); apply_cfg();
    repeat (10) @(negedge clk);
    run_up(1'b1);
    run_dn();

    // R7 R11 R10: stuck rail with watchdog
    pos = '{0, 3, 1, 0}; md = '{0, 0, 2, 1}; lat = '{2, 2, 2, 2};
    stuck[0] = 1; stuck[3] = 1;
    set_d(2, 20); apply_cfg();
    repeat (10) @(negedge clk);
    chk(en_o[2] == 1'b1, "R11", "held-on enable while idle", en_o[2], 1);
    chk(en_o[3] == 1'b0, "R10", "held-off enable while idle", en_o[3], 0);
    clr_mon();
    @(negedge clk); on_i = 1'b1; t0 = cyc;
    while (cyc < t0 + 1 + 3 + 20) @(negedge clk);
    chk(flt_no == 1'b1, "R7", "fault before limit", flt_no, 1);
    @(negedge clk);
    chk(flt_no == 1'b0, "R7", "fault at limit", flt_no, 0);
    chk(en_o == '0, "R7", "enables on fault", en_o, 0);
    chk(rise[1] == -1, "R4", "later slot while stalled", rise[1], -1);
    repeat (10) @(negedge clk);
    chk(flt_no == 1'b0, "R9", "fault held with run high", flt_no, 0);
    on_i = 1'b0; stuck[0] = 0;
    repeat (6) @(negedge clk);
    chk(flt_no == 1'b0, "R9", "fault held after run low", flt_no, 0);
    chk(en_o[2] == 1'b0, "R11", "held-on enable during fault", en_o[2], 0);
    pg_lim_i = '0;
    @(negedge clk); on_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(flt_no == 1'b1, "R9", "fault cleared on run rise", flt_no, 1);
    chk(en_o[2] == 1'b1, "R11", "held-on enable after clear", en_o[2], 1);
    repeat (budget()) @(negedge clk);
    chk(en_o == 4'b0111, "R9 R10", "enables after restart", en_o, 4'b0111);
    run_dn();
    chk(en_o == 4'b0100, "R11", "only held-on enable after down", en_o, 4'b0100);

    // R8: watchdog disabled, stalled rail
    pos = '{0, 3, 6, 7}; md = '{0, 0, 1, 1}; lat = '{2, 2, 2, 2};
    stuck[0] = 1;
    set_d(1, 0); apply_cfg();
    repeat (5) @(negedge clk);
    @(negedge clk); on_i = 1'b1;
    repeat (400) @(negedge clk);
    chk(flt_no == 1'b1, "R8", "no fault with limit 0", flt_no, 1);
    chk(en_o == 4'b0001, "R4", "stalled at first slot", en_o, 1);
    stuck[0] = 0;
    repeat (budget()) @(negedge clk);
    chk(en_o == 4'b0011, "R4", "resumed after rail ok", en_o, 3);
    run_dn();

    // R12: reversal partway up
    pos = '{1, 5, 0, 0}; md = '{0, 0, 1, 1}; lat = '{3, 3, 1, 1};
    set_d(4, 0); apply_cfg();
    repeat (5) @(negedge clk);
    clr_mon();
    @(negedge clk); on_i = 1'b1;
    for (int k = 0; k < 200 && rise[0] == -1; k++) @(negedge clk);
    @(negedge clk); on_i = 1'b0;
    repeat (200) @(negedge clk);
    chk(rise[1] == -1, "R12", "unreached slot switched", rise[1], -1);
    chk(fall[0] != -1, "R12", "reached slot lowered", fall[0], 1);
    chk(en_o == '0, "R12", "enables after reversal", en_o, 0);
    chk(flt_no == 1'b1, "R12", "no fault on reversal", flt_no, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule